// File: doc/BRIEF.md
# DMA Transfer Hierarchy Event Generator

This block follows the nested structure of one DMA channel's work while a separate engine moves the data. Beats make up a fragment, fragments make up a block and blocks make up a transaction. It counts accepted beats against a programmed fragment length, fragment count per block and block count per transaction. At each boundary it emits one-cycle completion pulses: fragment done, block done and transaction done.

Software arms the channel with a start strobe, which also latches the configuration. The peripheral then raises request strobes. The request mode sets how much data one request may move: one fragment, one block, or the whole transaction. Link-list mode is treated here as a whole transaction. For each accepted request the block holds a grant and reports the unit size in beats, until that unit is finished.

A programmable interrupt-type code picks which completion levels set a level interrupt. Software clears the interrupt by writing one. A configuration that cannot run is refused and flagged.

Top module: `xfer_level_evgen`

## Requirements
- R1: After a synchronous active-low reset, `grant`, `busy`, `frag_done`, `blk_done`, `txn_done`, `irq` and `cfg_err` are all 0.
- R2: While `grant` is high, `frag_done` pulses for one cycle in the cycle after the beat that completes `cfg_frag_len` accepted beats. A `beat_acc` while `grant` is low is ignored and does not count.
- R3: `blk_done` pulses together with the `frag_done` that completes a block's fragment count. `txn_done` pulses together with the `blk_done` and `frag_done` that complete the last block. `busy` falls in that same cycle.
- R4: The request mode code selects the unit of one request: 0 = one fragment, 1 = one block, 2 = one transaction, 3 = link-list, served as one transaction. `grant_beats` equals that unit in beats, from the start onward. `grant` rises the cycle after an accepted request and falls in the cycle the unit's completion pulse appears.
- R5: A `per_req` while `grant` is high, or while `busy` is low, is ignored. No grant follows it.
- R6: Interrupt-type codes set `irq`, in the same cycle as the matching pulse, as follows: 0 = never; 1 = fragment; 2 = block; 3 = block or fragment; 4 = transaction; 5 = transaction or fragment; 6 = transaction or block.
- R7: `irq` is a level that holds until an `irq_clr` strobe. If a selected completion falls in the same cycle as the clear, `irq` stays set.
- R8: Code 7 sets `irq` on transaction completion only when the request mode is 3. In other modes code 7 raises nothing.
- R9: A start with a zero fragment length, a zero fragment count, a zero block count or an interrupt code above 8 is refused: `busy` stays 0 and `cfg_err` becomes 1. When such a start carries code 8, `irq` is also set. A later accepted start clears `cfg_err`.
- R10: A start while `busy` is high is ignored, valid or not. The running configuration, `grant_beats` and `cfg_err` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arm strobe; latches the configuration |
| cfg_frag_len | input | LEN_W | Beats per fragment |
| cfg_frags_per_blk | input | CNT_W | Fragments per block |
| cfg_blks_per_txn | input | CNT_W | Blocks per transaction |
| cfg_req_mode | input | 2 | Request mode code |
| cfg_irq_sel | input | 4 | Interrupt-type code |
| per_req | input | 1 | Peripheral request strobe |
| beat_acc | input | 1 | Beat accepted by the engine |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| grant | output | 1 | Engine may move beats of the current unit |
| grant_beats | output | LEN_W+2*CNT_W | Beats in one granted unit |
| busy | output | 1 | Channel armed, transaction in progress |
| frag_done | output | 1 | Fragment completion pulse |
| blk_done | output | 1 | Block completion pulse |
| txn_done | output | 1 | Transaction completion pulse |
| irq | output | 1 | Interrupt status level |
| cfg_err | output | 1 | Configuration error flag |

## Verification
Two things can land in one cycle: a software clear of the interrupt, and a completion that the interrupt selection names. The bench provokes this by driving `irq_clr` together with the beat that closes a fragment in transaction-or-fragment mode. It expects `irq` to stay high afterwards. It then repeats the clear on a beat that closes nothing and expects `irq` to fall. A second overlap is a request that arrives while a unit is still granted. The bench judges it by `grant` staying low once that unit ends.

// File: rtl/xle_pkg.sv
// Package: shared codes for the transfer hierarchy event generator.
// Assumes codes are fixed by software convention and never renumbered.
package xle_pkg;

    typedef enum logic [1:0] {
        RQ_FRAG  = 2'd0,
        RQ_BLOCK = 2'd1,
        RQ_TXN   = 2'd2,
        RQ_LIST  = 2'd3
    } rq_mode_e;

    localparam logic [3:0] IRQ_NONE     = 4'd0;
    localparam logic [3:0] IRQ_FRAG     = 4'd1;
    localparam logic [3:0] IRQ_BLK      = 4'd2;
    localparam logic [3:0] IRQ_BLK_FRAG = 4'd3;
    localparam logic [3:0] IRQ_TXN      = 4'd4;
    localparam logic [3:0] IRQ_TXN_FRAG = 4'd5;
    localparam logic [3:0] IRQ_TXN_BLK  = 4'd6;
    localparam logic [3:0] IRQ_LIST     = 4'd7;
    localparam logic [3:0] IRQ_CFGERR   = 4'd8;

endpackage

// File: rtl/xle_cfg_ctrl.sv
// Module: arm control. Validates the configuration on start, latches it,
// precomputes the unit size per request, and holds busy until the
// transaction ends. Assumes txn_end is only raised while busy.
module xle_cfg_ctrl
    import xle_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8,
    parameter int SIZE_W = LEN_W + 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_frag_len,
    input  logic [CNT_W-1:0]  cfg_frags_per_blk,
    input  logic [CNT_W-1:0]  cfg_blks_per_txn,
    input  logic [1:0]        cfg_req_mode,
    input  logic [3:0]        cfg_irq_sel,
    input  logic              txn_end,
    output logic              busy,
    output logic              cfg_err,
    output logic              start_ok,
    output logic              err_irq_ev,
    output logic [LEN_W-1:0]  run_len,
    output logic [CNT_W-1:0]  run_fpb,
    output logic [CNT_W-1:0]  run_bpt,
    output rq_mode_e          run_mode,
    output logic [3:0]        run_sel,
    output logic [SIZE_W-1:0] grant_beats
);

    logic              cfg_bad;
    logic              start_live;
    logic [SIZE_W-1:0] sz_frag;
    logic [SIZE_W-1:0] sz_blk;
    logic [SIZE_W-1:0] sz_txn;
    logic [SIZE_W-1:0] sz_sel;

    // Flag configurations that cannot run.
    always_comb begin
        cfg_bad = (cfg_frag_len == '0) || (cfg_frags_per_blk == '0) ||
                  (cfg_blks_per_txn == '0) || (cfg_irq_sel > IRQ_CFGERR);
    end

    assign start_live = start && !busy;
    assign start_ok   = start_live && !cfg_bad;
    assign err_irq_ev = start_live && cfg_bad && (cfg_irq_sel == IRQ_CFGERR);

    // Unit sizes for each request mode, from the incoming configuration.
    always_comb begin
        sz_frag = SIZE_W'(cfg_frag_len);
        sz_blk  = sz_frag * SIZE_W'(cfg_frags_per_blk);
        sz_txn  = sz_blk * SIZE_W'(cfg_blks_per_txn);
        case (rq_mode_e'(cfg_req_mode))
            RQ_FRAG:  sz_sel = sz_frag;
            RQ_BLOCK: sz_sel = sz_blk;
            default:  sz_sel = sz_txn;
        endcase
    end

    // Arm, refuse or finish the channel; latch the running configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            cfg_err     <= 1'b0;
            run_len     <= '0;
            run_fpb     <= '0;
            run_bpt     <= '0;
            run_mode    <= RQ_FRAG;
            run_sel     <= IRQ_NONE;
            grant_beats <= '0;
        end else if (start_live) begin
            if (cfg_bad) begin
                cfg_err <= 1'b1;
            end else begin
                cfg_err     <= 1'b0;
                busy        <= 1'b1;
                run_len     <= cfg_frag_len;
                run_fpb     <= cfg_frags_per_blk;
                run_bpt     <= cfg_blks_per_txn;
                run_mode    <= rq_mode_e'(cfg_req_mode);
                run_sel     <= cfg_irq_sel;
                grant_beats <= sz_sel;
            end
        end else if (txn_end) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/xle_level_cnt.sv
// Module: nested beat, fragment and block counters. Produces completion
// events combinationally on the closing beat and registers them into
// one-cycle pulses. Assumes the run configuration is nonzero and stable
// while beats are counted.
module xle_level_cnt
    import xle_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             beat_fire,
    input  logic [LEN_W-1:0] run_len,
    input  logic [CNT_W-1:0] run_fpb,
    input  logic [CNT_W-1:0] run_bpt,
    input  rq_mode_e         run_mode,
    output logic             ev_frag,
    output logic             ev_blk,
    output logic             ev_txn,
    output logic             unit_end,
    output logic             frag_done,
    output logic             blk_done,
    output logic             txn_done
);

    logic [LEN_W-1:0] beat_cnt;
    logic [CNT_W-1:0] frag_cnt;
    logic [CNT_W-1:0] blk_cnt;
    logic             last_beat;
    logic             last_frag;
    logic             last_blk;

    // Detect the last position at each level.
    always_comb begin
        last_beat = (beat_cnt == run_len - LEN_W'(1));
        last_frag = (frag_cnt == run_fpb - CNT_W'(1));
        last_blk  = (blk_cnt  == run_bpt - CNT_W'(1));
    end

    // Completion events on the closing beat, nested from fragment upward.
    always_comb begin
        ev_frag = beat_fire && last_beat;
        ev_blk  = ev_frag && last_frag;
        ev_txn  = ev_blk && last_blk;
    end

    // End of the unit that one request was granted for.
    always_comb begin
        case (run_mode)
            RQ_FRAG:  unit_end = ev_frag;
            RQ_BLOCK: unit_end = ev_blk;
            default:  unit_end = ev_txn;
        endcase
    end

    // Advance the nested counters on each counted beat.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            beat_cnt <= '0;
            frag_cnt <= '0;
            blk_cnt  <= '0;
        end else if (beat_fire) begin
            if (!last_beat) begin
                beat_cnt <= beat_cnt + LEN_W'(1);
            end else begin
                beat_cnt <= '0;
                if (!last_frag) begin
                    frag_cnt <= frag_cnt + CNT_W'(1);
                end else begin
                    frag_cnt <= '0;
                    if (!last_blk) begin
                        blk_cnt <= blk_cnt + CNT_W'(1);
                    end else begin
                        blk_cnt <= '0;
                    end
                end
            end
        end
    end

    // Register the events into completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frag_done <= 1'b0;
            blk_done  <= 1'b0;
            txn_done  <= 1'b0;
        end else begin
            frag_done <= ev_frag;
            blk_done  <= ev_blk;
            txn_done  <= ev_txn;
        end
    end

endmodule

// File: rtl/xle_serve.sv
// Module: request server. Accepts one peripheral request at a time while
// armed and holds grant until the granted unit completes. Assumes
// unit_end is only raised while grant is high.
module xle_serve (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic start_ok,
    input  logic per_req,
    input  logic unit_end,
    output logic grant
);

    // Grant on a request when idle and armed; drop at the end of the unit.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            grant <= 1'b0;
        end else if (grant) begin
            if (unit_end) begin
                grant <= 1'b0;
            end
        end else if (busy && per_req) begin
            grant <= 1'b1;
        end
    end

endmodule

// File: rtl/xle_irq_filter.sv
// Module: interrupt filter and status. Maps the interrupt-type code onto
// the completion events and keeps a write-one-to-clear level in which a
// new event wins over a clear in the same cycle.
module xle_irq_filter
    import xle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] run_sel,
    input  rq_mode_e   run_mode,
    input  logic       ev_frag,
    input  logic       ev_blk,
    input  logic       ev_txn,
    input  logic       err_irq_ev,
    input  logic       irq_clr,
    output logic       irq
);

    logic want_frag;
    logic want_blk;
    logic want_txn;
    logic want_list;
    logic hit;

    // Decode which levels the selected code names.
    always_comb begin
        want_frag = (run_sel == IRQ_FRAG) || (run_sel == IRQ_BLK_FRAG) ||
                    (run_sel == IRQ_TXN_FRAG);
        want_blk  = (run_sel == IRQ_BLK) || (run_sel == IRQ_BLK_FRAG) ||
                    (run_sel == IRQ_TXN_BLK);
        want_txn  = (run_sel == IRQ_TXN) || (run_sel == IRQ_TXN_FRAG) ||
                    (run_sel == IRQ_TXN_BLK);
        want_list = (run_sel == IRQ_LIST) && (run_mode == RQ_LIST);
    end

    // Any selected event in this cycle.
    always_comb begin
        hit = (want_frag && ev_frag) || (want_blk && ev_blk) ||
              ((want_txn || want_list) && ev_txn) || err_irq_ev;
    end

    // Status level: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (hit) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/xfer_level_evgen.sv
// Module: top of the transfer hierarchy event generator. Ties together
// arm control, nested counters, request server and interrupt filter.
// Assumes the engine only asserts beat_acc for beats it really moved.
module xfer_level_evgen
    import xle_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 8,
    localparam int SIZE_W = LEN_W + 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_frag_len,
    input  logic [CNT_W-1:0]  cfg_frags_per_blk,
    input  logic [CNT_W-1:0]  cfg_blks_per_txn,
    input  logic [1:0]        cfg_req_mode,
    input  logic [3:0]        cfg_irq_sel,
    input  logic              per_req,
    input  logic              beat_acc,
    input  logic              irq_clr,
    output logic              grant,
    output logic [SIZE_W-1:0] grant_beats,
    output logic              busy,
    output logic              frag_done,
    output logic              blk_done,
    output logic              txn_done,
    output logic              irq,
    output logic              cfg_err
);

    logic             start_ok;
    logic             err_irq_ev;
    logic [LEN_W-1:0] run_len;
    logic [CNT_W-1:0] run_fpb;
    logic [CNT_W-1:0] run_bpt;
    rq_mode_e         run_mode;
    logic [3:0]       run_sel;
    logic             ev_frag;
    logic             ev_blk;
    logic             ev_txn;
    logic             unit_end;
    logic             beat_fire;

    assign beat_fire = beat_acc && grant;

    xle_cfg_ctrl #(
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .SIZE_W (SIZE_W)
    ) u_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .start             (start),
        .cfg_frag_len      (cfg_frag_len),
        .cfg_frags_per_blk (cfg_frags_per_blk),
        .cfg_blks_per_txn  (cfg_blks_per_txn),
        .cfg_req_mode      (cfg_req_mode),
        .cfg_irq_sel       (cfg_irq_sel),
        .txn_end           (ev_txn),
        .busy              (busy),
        .cfg_err           (cfg_err),
        .start_ok          (start_ok),
        .err_irq_ev        (err_irq_ev),
        .run_len           (run_len),
        .run_fpb           (run_fpb),
        .run_bpt           (run_bpt),
        .run_mode          (run_mode),
        .run_sel           (run_sel),
        .grant_beats       (grant_beats)
    );

    xle_level_cnt #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .beat_fire (beat_fire),
        .run_len   (run_len),
        .run_fpb   (run_fpb),
        .run_bpt   (run_bpt),
        .run_mode  (run_mode),
        .ev_frag   (ev_frag),
        .ev_blk    (ev_blk),
        .ev_txn    (ev_txn),
        .unit_end  (unit_end),
        .frag_done (frag_done),
        .blk_done  (blk_done),
        .txn_done  (txn_done)
    );

    xle_serve u_serve (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .start_ok (start_ok),
        .per_req  (per_req),
        .unit_end (unit_end),
        .grant    (grant)
    );

    xle_irq_filter u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_sel    (run_sel),
        .run_mode   (run_mode),
        .ev_frag    (ev_frag),
        .ev_blk     (ev_blk),
        .ev_txn     (ev_txn),
        .err_irq_ev (err_irq_ev),
        .irq_clr    (irq_clr),
        .irq        (irq)
    );

endmodule

// File: rtl/xle_checker.sv
// Module: protocol checker for the event generator, bound to the top.
// Assumes it sees the top-level ports only.
module xle_checker (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic busy,
    input logic frag_done,
    input logic blk_done,
    input logic txn_done,
    input logic irq,
    input logic irq_clr,
    input logic cfg_err
);

    AST_BLK_WITH_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> frag_done); // R3

    AST_TXN_WITH_BLK: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |-> (blk_done && !busy)); // R3

    AST_FRAG_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        frag_done |-> $past(grant)); // R2

    AST_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy); // R4

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R7

    AST_ERR_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy); // R9

endmodule

bind xfer_level_evgen xle_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .busy      (busy),
    .frag_done (frag_done),
    .blk_done  (blk_done),
    .txn_done  (txn_done),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .cfg_err   (cfg_err)
);

// File: tb/xfer_level_evgen_bench.sv
// Bench: directed scenarios, each task checks its own results.
module xfer_level_evgen_bench;

    localparam int LEN_W  = 8;
    localparam int CNT_W  = 8;
    localparam int SIZE_W = LEN_W + 2 * CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  cfg_frag_len = '0;
    logic [CNT_W-1:0]  cfg_frags_per_blk = '0;
    logic [CNT_W-1:0]  cfg_blks_per_txn = '0;
    logic [1:0]        cfg_req_mode = '0;
    logic [3:0]        cfg_irq_sel = '0;
    logic              per_req = 1'b0;
    logic              beat_acc = 1'b0;
    logic              irq_clr = 1'b0;
    logic              grant;
    logic [SIZE_W-1:0] grant_beats;
    logic              busy;
    logic              frag_done;
    logic              blk_done;
    logic              txn_done;
    logic              irq;
    logic              cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xfer_level_evgen #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_xfer_level_evgen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_frag_len(cfg_frag_len), .cfg_frags_per_blk(cfg_frags_per_blk),
        .cfg_blks_per_txn(cfg_blks_per_txn), .cfg_req_mode(cfg_req_mode),
        .cfg_irq_sel(cfg_irq_sel), .per_req(per_req), .beat_acc(beat_acc),
        .irq_clr(irq_clr), .grant(grant), .grant_beats(grant_beats),
        .busy(busy), .frag_done(frag_done), .blk_done(blk_done),
        .txn_done(txn_done), .irq(irq), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic arm(input int len, input int fpb, input int bpt,
                       input int mode, input int sel);
        cfg_frag_len      = LEN_W'(len);
        cfg_frags_per_blk = CNT_W'(fpb);
        cfg_blks_per_txn  = CNT_W'(bpt);
        cfg_req_mode      = 2'(mode);
        cfg_irq_sel       = 4'(sel);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic request();
        per_req = 1'b1;
        @(negedge clk);
        per_req = 1'b0;
    endtask

    task automatic beat(input bit clr);
        beat_acc = 1'b1;
        irq_clr  = clr;
        @(negedge clk);
        beat_acc = 1'b0;
        irq_clr  = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 grant", int'(grant), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done pulses", int'({frag_done, blk_done, txn_done}), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
    endtask

    // Fragment mode, 3 beats x 2 fragments x 2 blocks, irq on fragments.
    task automatic t_frag_mode();
        arm(3, 2, 2, 0, 1);
        chk("R4 frag unit size", int'(grant_beats), 3);
        chk("R4 busy after start", int'(busy), 1);
        beat(0);
        beat(0);
        chk("R2 beats without grant no pulse", int'(frag_done), 0);
        for (int f = 0; f < 4; f++) begin
            request();
            chk("R4 grant after request", int'(grant), 1);
            for (int b = 0; b < 3; b++) begin
                beat(0);
                if (b < 2) begin
                    chk("R2 no early fragment", int'(frag_done), 0);
                end else begin
                    chk("R2 fragment done", int'(frag_done), 1);
                    chk("R3 block done", int'(blk_done), (f % 2 == 1) ? 1 : 0);
                    chk("R3 transaction done", int'(txn_done), (f == 3) ? 1 : 0);
                    chk("R4 grant drops at unit end", int'(grant), 0);
                    chk("R6 code 1 irq on fragment", int'(irq), 1);
                    chk("R3 busy", int'(busy), (f == 3) ? 0 : 1);
                end
            end
            clear_irq();
            chk("R7 clear drops irq", int'(irq), 0);
        end
    endtask

    // Block mode, 2 x 3 x 2, irq on blocks only; overlapping request.
    task automatic t_block_mode();
        arm(2, 3, 2, 1, 2);
        chk("R4 block unit size", int'(grant_beats), 6);
        for (int k = 0; k < 2; k++) begin
            request();
            for (int b = 1; b <= 6; b++) begin
                if (b == 3) per_req = 1'b1;
                beat(0);
                per_req = 1'b0;
                chk("R2 fragment every two beats", int'(frag_done), (b % 2 == 0) ? 1 : 0);
                if (b == 2) chk("R6 code 2 ignores fragment", int'(irq), 0);
            end
            chk("R3 block done", int'(blk_done), 1);
            chk("R6 code 2 irq on block", int'(irq), 1);
            chk("R3 txn on last block", int'(txn_done), k);
            @(negedge clk);
            chk("R5 request during grant ignored", int'(grant), 0);
            clear_irq();
        end
        chk("R3 busy off after transaction", int'(busy), 0);
        request();
        chk("R5 request while idle ignored", int'(grant), 0);
    endtask

    // Transaction mode, code 5, clear colliding with a completion.
    task automatic t_txn_mode();
        arm(2, 2, 2, 2, 5);
        chk("R4 transaction unit size", int'(grant_beats), 8);
        request();
        for (int b = 1; b <= 8; b++) begin
            beat((b == 4 || b == 5) ? 1'b1 : 1'b0);
            if (b == 2) chk("R6 code 5 irq on fragment", int'(irq), 1);
            if (b == 4) chk("R7 set wins over clear", int'(irq), 1);
            if (b == 5) chk("R7 clear on quiet cycle", int'(irq), 0);
            if (b == 7) chk("R4 grant held within transaction", int'(grant), 1);
        end
        chk("R3 all three pulses", int'({frag_done, blk_done, txn_done}), 7);
        chk("R6 code 5 irq at end", int'(irq), 1);
        chk("R3 busy off", int'(busy), 0);
        clear_irq();
    endtask

    // Code 7 raises only in link-list mode.
    task automatic t_list_mode();
        arm(1, 1, 2, 3, 7);
        chk("R4 list unit size", int'(grant_beats), 2);
        request();
        beat(0);
        chk("R8 no irq on block", int'(irq), 0);
        beat(0);
        chk("R8 list done irq", int'(irq), 1);
        chk("R8 txn pulse", int'(txn_done), 1);
        clear_irq();
        arm(1, 1, 2, 2, 7);
        request();
        beat(0);
        beat(0);
        chk("R8 code 7 outside list mode", int'(irq), 0);
        chk("R8 txn pulse outside list", int'(txn_done), 1);
    endtask

    // Invalid configurations are refused.
    task automatic t_cfg_err();
        arm(0, 1, 1, 0, 1);
        chk("R9 zero length error", int'(cfg_err), 1);
        chk("R9 zero length not busy", int'(busy), 0);
        chk("R9 code 1 no irq on error", int'(irq), 0);
        request();
        chk("R9 refused channel no grant", int'(grant), 0);
        arm(2, 0, 1, 0, 8);
        chk("R9 zero count error", int'(cfg_err), 1);
        chk("R9 code 8 irq", int'(irq), 1);
        clear_irq();
        arm(2, 1, 0, 0, 9);
        chk("R9 zero blocks with code 9", int'(cfg_err), 1);
        chk("R9 code 9 no irq", int'(irq), 0);
        arm(1, 1, 1, 0, 9);
        chk("R9 code above 8 error", int'(cfg_err), 1);
        arm(1, 1, 1, 2, 8);
        chk("R9 valid start clears error", int'(cfg_err), 0);
        chk("R9 valid start busy", int'(busy), 1);
        request();
        beat(0);
        chk("R9 code 8 silent on valid run", int'(irq), 0);
        chk("R9 valid run ends", int'(busy), 0);
    endtask

    // A start while busy changes nothing.
    task automatic t_start_busy();
        arm(4, 1, 1, 0, 0);
        chk("R10 first size", int'(grant_beats), 4);
        arm(7, 1, 1, 0, 0);
        chk("R10 restart ignored", int'(grant_beats), 4);
        arm(0, 1, 1, 0, 0);
        chk("R10 bad restart no error", int'(cfg_err), 0);
        request();
        for (int b = 1; b <= 4; b++) begin
            beat(0);
        end
        chk("R10 original length kept", int'(txn_done), 1);
        chk("R6 code 0 never", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frag_mode();
        t_block_mode();
        t_txn_mode();
        t_list_mode();
        t_cfg_err();
        t_start_busy();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule